// File: doc/BRIEF.md
# Fuse Array Byte Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro. A request gives a 10-bit start byte address and a byte count. The sequencer opens the macro in read mode and steps through the addresses one at a time. For each address it drives the macro's chip-select, program-enable, load, strobe and address pins in a fixed order, with a programmable settle gap between phases. It returns each byte on a valid/ready stream.

When the last byte has been read, the macro is parked in standby. The settle gap is a parameter counted in clock cycles. At 100 MHz the default of 100 cycles gives roughly one microsecond. A bench can shorten it. Fuse programming is never performed: the program-enable pin (active low) is held high at all times.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset and whenever idle, the macro sits in standby: chip-select (active low) high, program-enable (active low) high, load low, strobe low, address 0. Busy and out_valid are low.
- R2: An accepted request with a nonzero count drives chip-select low and load high, with program-enable still high. The first strobe rises exactly 2*SETTLE_CYC+1 cycles after chip-select falls. Strobe is high only while chip-select is low and load is high.
- R3: For every byte, the address is shown as 0 before the new address is applied. Strobe stays high for at least SETTLE_CYC cycles, and for exactly SETTLE_CYC when the output is free. The address does not change while strobe is high. From strobe falling to the next strobe rising is exactly 2*SETTLE_CYC+1 cycles.
- R4: Each returned byte equals the macro data at the address under strobe. Bytes are returned in address order, and exactly count bytes are returned.
- R5: The byte address starts at the requested address and steps by one per byte, wrapping from 1023 to 0.
- R6: Exactly SETTLE_CYC cycles after the last strobe falls, chip-select goes high, load goes low and busy goes low together.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable. The sequencer holds strobe instead of dropping a byte.
- R8: A request with count 0 raises busy for exactly one cycle. It never lowers chip-select and never raises strobe.
- R9: A request presented while busy is high is ignored. It neither alters the current run nor starts a later one.
- R10: Busy rises in the cycle after a request is accepted. Busy stays high whenever chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqAddr | input | 10 | Start byte address |
| reqCount | input | 11 | Number of bytes to read |
| busy | output | 1 | Run in progress |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Consumer accepts byte |
| outData | output | 8 | Returned byte |
| fuseCsN | output | 1 | Macro chip-select, active low |
| fusePgenN | output | 1 | Macro program enable, active low, held high |
| fuseLoad | output | 1 | Macro load (read) mode |
| fuseStrobe | output | 1 | Macro read strobe |
| fuseAddr | output | 10 | Macro byte address |
| fuseDout | input | 8 | Macro read data |

## Verification
Each pin event is due a fixed number of cycles after the previous one, and the bench checks these counts against a free-running cycle counter:
- Busy is due one edge after acceptance.
- The first strobe rise is due 2*SETTLE_CYC+1 cycles after chip-select falls.
- Each later strobe rise is due 2*SETTLE_CYC+1 cycles after the previous fall.
- Chip-select release is due SETTLE_CYC cycles after the last fall.

Inputs change one time unit after a rising edge, and every output is sampled on the falling edge. Each result is therefore compared in the cycle in which it is due. Data bytes are compared at each valid/ready handshake against a bench function of the expected wrapped address.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_CLR,
    ST_SETA,
    ST_STRB,
    ST_DROP,
    ST_ZDONE
  } seqState_t;

  typedef struct packed {
    logic accept;
    logic waitRst;
    logic sample;
    logic advance;
    logic addrShow;
  } seqCtl_t;

endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqZero,
  input  logic    waitDone,
  input  logic    lastByte,
  input  logic    outFree,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    fuseCsN,
  output logic    fusePgenN,
  output logic    fuseLoad,
  output logic    fuseStrobe
);

  seqState_t st, nxt;
  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    case (st)
      ST_IDLE: if (reqValid) begin
        ctl.accept  = 1'b1;
        ctl.waitRst = 1'b1;
        nxt = reqZero ? ST_ZDONE : ST_OPEN;
      end
      ST_OPEN: if (waitDone) begin
        ctl.waitRst = 1'b1;
        nxt = ST_CLR;
      end
      ST_CLR: begin
        ctl.waitRst = 1'b1;
        nxt = ST_SETA;
      end
      ST_SETA: if (waitDone) begin
        ctl.waitRst = 1'b1;
        nxt = ST_STRB;
      end
      ST_STRB: if (waitDone && outFree) begin
        ctl.sample  = 1'b1;
        ctl.waitRst = 1'b1;
        nxt = ST_DROP;
      end
      ST_DROP: if (waitDone) begin
        ctl.advance = 1'b1;
        ctl.waitRst = 1'b1;
        nxt = lastByte ? ST_IDLE : ST_CLR;
      end
      ST_ZDONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    ctl.addrShow = (st == ST_SETA) || (st == ST_STRB) || (st == ST_DROP);
  end

  assign active     = (st == ST_OPEN) || (st == ST_CLR) || (st == ST_SETA) ||
                      (st == ST_STRB) || (st == ST_DROP);
  assign busy       = (st != ST_IDLE);
  assign fuseCsN    = !active;
  assign fuseLoad   = active;
  assign fusePgenN  = 1'b1;
  assign fuseStrobe = (st == ST_STRB);

endmodule

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 11,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DATA_W-1:0] fuseDout,
  input  logic              outReady,
  output logic              waitDone,
  output logic              lastByte,
  output logic              outFree,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [ADDR_W-1:0] fuseAddr
);

  localparam int WAIT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYC - 1);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain  <= '0;
    end else if (ctl.accept) begin
      curAddr <= reqAddr;
      remain  <= reqCount;
    end else if (ctl.advance) begin
      curAddr <= curAddr + 1'b1;
      remain  <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (ctl.waitRst)   waitCnt <= '0;
    else if (!waitDone)     waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (ctl.sample) begin
      outValid <= 1'b1;
      outData  <= fuseDout;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign waitDone = (waitCnt == WAIT_LAST);
  assign lastByte = (remain == CNT_W'(1));
  assign outFree  = !outValid || outReady;
  assign fuseAddr = ctl.addrShow ? curAddr : '0;

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 11,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              busy,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              fuseCsN,
  output logic              fusePgenN,
  output logic              fuseLoad,
  output logic              fuseStrobe,
  output logic [ADDR_W-1:0] fuseAddr,
  input  logic [DATA_W-1:0] fuseDout
);

  seqCtl_t ctl;
  logic waitDone, lastByte, outFree;

  fuse_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZero(reqCount == '0),
    .waitDone(waitDone), .lastByte(lastByte), .outFree(outFree),
    .ctl(ctl), .busy(busy), .fuseCsN(fuseCsN), .fusePgenN(fusePgenN),
    .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe)
  );

  fuse_seq_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqCount(reqCount),
    .fuseDout(fuseDout), .outReady(outReady), .waitDone(waitDone),
    .lastByte(lastByte), .outFree(outFree), .outValid(outValid),
    .outData(outData), .fuseAddr(fuseAddr)
  );

endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              fuseCsN,
  input logic              fusePgenN,
  input logic              fuseLoad,
  input logic              fuseStrobe,
  input logic [ADDR_W-1:0] fuseAddr
);

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (fuseCsN && fusePgenN && !fuseLoad && !fuseStrobe)); // R1

  AST_STROBE_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> (!fuseCsN && fuseLoad && fusePgenN)); // R2

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> $stable(fuseAddr)); // R3

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R7

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy); // R10

  AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !fuseCsN |-> busy); // R10

endmodule

bind fuse_read_seq fuse_read_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .fuseCsN(fuseCsN), .fusePgenN(fusePgenN), .fuseLoad(fuseLoad),
  .fuseStrobe(fuseStrobe), .fuseAddr(fuseAddr)
);

// File: tb/fuse_read_seq_bench.sv
module fuse_read_seq_bench;

  localparam int W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [10:0] reqCount = '0;
  logic        outReady = 1'b1;
  logic        busy, outValid, fuseCsN, fusePgenN, fuseLoad, fuseStrobe;
  logic [7:0]  outData, fuseDout;
  logic [9:0]  fuseAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit exactMode = 1'b0;

  // monitor state
  int rises, rxIdx, csFalls, csFallCyc, strbRiseCyc, strbFallCyc;
  int startAddr;
  bit sawZero;
  logic prevStrobe = 1'b0, prevCsN = 1'b1, prevValid = 1'b0, prevReady = 1'b1;
  logic [7:0] prevData = '0;

  always #5 clk = ~clk;

  function automatic logic [7:0] fuseByte(input logic [9:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd13;
    return m ^ {a[9:8], a[9:8], a[9:8], a[9:8]} ^ 8'hA5;
  endfunction

  assign fuseDout = fuseStrobe ? fuseByte(fuseAddr) : 8'h00;

  fuse_read_seq #(.SETTLE_CYC(W)) u_fuse_read_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCount(reqCount), .busy(busy), .outValid(outValid), .outReady(outReady),
    .outData(outData), .fuseCsN(fuseCsN), .fusePgenN(fusePgenN),
    .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe), .fuseAddr(fuseAddr),
    .fuseDout(fuseDout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && !busy) begin
        rises = 0; rxIdx = 0; csFalls = 0; sawZero = 1'b0;
        startAddr = int'(reqAddr);
      end
      if (prevCsN && !fuseCsN) begin
        csFalls++; csFallCyc = cyc; sawZero = 1'b0;
      end
      if (!fuseCsN) chk(busy == 1'b1, "R10", "busy while cs low", int'(busy), 1);
      if (!fuseStrobe && !fuseCsN && fuseAddr == '0 && !prevStrobe) sawZero = 1'b1;
      if (fuseStrobe && !prevStrobe) begin
        rises++;
        chk(fuseAddr == 10'((startAddr + rises - 1) % 1024), "R5", "strobe address",
            int'(fuseAddr), (startAddr + rises - 1) % 1024);
        chk(sawZero, "R3", "address cleared before apply", int'(sawZero), 1);
        sawZero = 1'b0;
        if (rises == 1)
          chk(cyc - csFallCyc == 2*W+1, "R2", "cs-to-first-strobe cycles",
              cyc - csFallCyc, 2*W+1);
        else
          chk(cyc - strbFallCyc == 2*W+1, "R3", "strobe low gap",
              cyc - strbFallCyc, 2*W+1);
        chk(!fuseCsN && fuseLoad && fusePgenN, "R2", "pins at strobe", 0, 0);
        strbRiseCyc = cyc;
      end
      if (!fuseStrobe && prevStrobe) begin
        if (exactMode)
          chk(cyc - strbRiseCyc == W, "R3", "strobe high length", cyc - strbRiseCyc, W);
        else
          chk(cyc - strbRiseCyc >= W, "R3", "strobe high min length", cyc - strbRiseCyc, W);
        strbFallCyc = cyc;
      end
      if (fuseCsN && !prevCsN) begin
        chk(cyc - strbFallCyc == W, "R6", "last strobe to standby", cyc - strbFallCyc, W);
        chk(!busy && !fuseLoad && fusePgenN && !fuseStrobe, "R6", "standby pins",
            int'(busy), 0);
      end
      if (prevValid && !prevReady)
        chk(outValid && outData == prevData, "R7", "held byte", int'(outData), int'(prevData));
      if (outValid && outReady) begin
        chk(outData == fuseByte(10'((startAddr + rxIdx) % 1024)), "R4", "returned byte",
            int'(outData), int'(fuseByte(10'((startAddr + rxIdx) % 1024))));
        rxIdx++;
      end
    end
    prevStrobe = fuseStrobe; prevCsN = fuseCsN;
    prevValid = outValid; prevReady = outReady; prevData = outData;
  end

  task automatic doRead(input int addr, input int cnt, input bit randReady,
                        input bit spurious);
    int i;
    @(posedge clk); #1;
    reqAddr = 10'(addr); reqCount = 11'(cnt); reqValid = 1'b1;
    exactMode = !randReady; outReady = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
    i = 0;
    while (busy || outValid) begin
      if (randReady) outReady = ($urandom % 3) != 0;
      if (spurious && i == 10) begin
        reqValid = 1'b1; reqAddr = 10'(addr + 77); reqCount = 11'd5;
      end else reqValid = 1'b0;
      @(posedge clk); #1;
      i++;
    end
    reqValid = 1'b0; outReady = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(rxIdx == cnt, "R4", "bytes returned", rxIdx, cnt);
    chk(rises == cnt, "R3", "strobe pulses", rises, cnt);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(fuseCsN && fusePgenN && !fuseLoad && !fuseStrobe && fuseAddr == '0,
        "R1", "reset standby pins", int'(fuseCsN), 1);
    chk(!busy && !outValid, "R1", "reset busy/valid", int'(busy), 0);

    doRead(5, 4, 1'b0, 1'b0);          // R2 R3 R4 R5 R6 directed
    doRead(1022, 4, 1'b0, 1'b0);       // R5 wrap
    // R8 zero count
    @(posedge clk); #1;
    reqAddr = 10'd40; reqCount = '0; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk(busy == 1'b1, "R8", "zero count busy pulse", int'(busy), 1);
    @(posedge clk); #1;
    chk(busy == 1'b0, "R8", "zero count done", int'(busy), 0);
    repeat (2) @(posedge clk);
    #1;
    chk(rises == 0 && csFalls == 0, "R8", "no strobe or cs", rises + csFalls, 0);

    doRead(100, 6, 1'b1, 1'b0);        // R7 backpressure
    doRead(300, 3, 1'b0, 1'b1);        // R9 request during busy
    repeat (5) begin
      @(negedge clk);
      chk(!busy && fuseCsN, "R9", "ignored request not queued", int'(busy), 0);
    end
    doRead(1023, 1, 1'b0, 1'b0);       // R5 single byte at top
    for (int k = 0; k < 10; k++)
      doRead(int'($urandom % 1024), int'($urandom % 8) + 1, k[0], 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule